// File: doc/BRIEF.md
# Floating-Point Exception Trap Gate

This block sits beside a floating-point datapath and decides what a reported exception does. Each cycle it can accept one explicit exception code from the arithmetic logic. It also watches a read operand's sign and exponent, so that it can raise the undefined-variable exception by itself. A set of per-exception enable bits and a global interrupt-disable bit come from the floating status register. From these the gate decides whether the exception is masked, whether the status error flag gets set, and whether a trap request with the fixed floating-point vector goes to the CPU.

In the same cycle it also tells the datapath whether to cancel the faulting instruction's writeback and condition codes, or to let the instruction finish. The exception code and the faulting instruction address are captured whenever the error flag is set, so that a trap handler can read them later. The trap request is a level that stays up until the CPU acknowledges it.

Top module: `fpx_trap_gate`

## Requirements
- R1: The code shifted right by one selects the enable. Index 3 (code 6, integer conversion) uses `en_mask[0]`, index 4 (code 8, overflow) uses `en_mask[1]`, index 5 (code 10, underflow) uses `en_mask[2]` and index 6 (code 12, undefined variable) uses `en_mask[3]`. Codes whose index is 0 to 2 or 7 cannot be masked.
- R2: A maskable event whose enable bit is 0 is masked. It raises no trap request and leaves `err_flag`, `code_reg` and `addr_reg` unchanged.
- R3: An event that is not masked sets `err_flag` at the next clock edge. At the same edge it loads the event code into `code_reg` and `insn_addr` into `addr_reg`.
- R4: An event that is not masked raises `trap_req` at the next clock edge, unless `int_dis` is 1. With `int_dis` at 1, the error flag and the captured registers are still updated.
- R5: `trap_req` stays high until a cycle in which `trap_ack` is 1, and it clears at that cycle's edge. A new firing event in the ack cycle keeps it high. `trap_vec` reads 164 (octal 244) while `trap_req` is high and reads 0 otherwise.
- R6: `nop_insn` is combinational and asserted in the event's own cycle. It is 1 for code 2 (illegal address mode) and code 4 (divide by zero), whatever the enables say. It is 1 for code 12 only when that event is not masked, and it is 0 for every other code.
- R7: With `opnd_valid` at 1, `opnd_sign` at 1 and `opnd_exp` at 0, the block forms an event with code 12 even when `exc_valid` is 0. When `exc_valid` is 1 in the same cycle, the explicit code takes precedence.
- R8: `stat_wr` loads `stat_err_in` into `err_flag`. When an event fires in the same cycle, `err_flag` becomes 1 instead.
- R9: After reset, `trap_req`, `err_flag`, `code_reg`, `addr_reg` and `trap_vec` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Explicit exception reported this cycle |
| exc_code | input | 4 | Explicit exception code |
| insn_addr | input | 16 | Address of the current instruction |
| opnd_valid | input | 1 | A floating operand is read this cycle |
| opnd_sign | input | 1 | Sign bit of that operand |
| opnd_exp | input | 8 | Exponent field of that operand |
| en_mask | input | 4 | Per-exception enables (see R1) |
| int_dis | input | 1 | Global floating interrupt disable |
| stat_wr | input | 1 | Status write of the error flag |
| stat_err_in | input | 1 | Value written to the error flag |
| trap_ack | input | 1 | CPU accepts the pending trap |
| trap_req | output | 1 | Pending trap request |
| trap_vec | output | 9 | Trap vector while requested, else 0 |
| nop_insn | output | 1 | Cancel current instruction's writeback |
| err_flag | output | 1 | Floating error flag |
| code_reg | output | 4 | Captured exception code |
| addr_reg | output | 16 | Captured faulting instruction address |

## Verification
The case hardest to reach from the ports is an undefined-variable event that is masked. In that case the instruction must complete, so `nop_insn` stays 0, and at the same time no flag or captured state may change. This has to hold even when the event comes from the operand detector and not from an explicit code. The stimulus reaches it with directed steps that clear `en_mask[3]` while feeding a zero-exponent negative operand. It also runs a seeded random phase that mixes explicit and detected events, toggles the enables, interrupt disable and status writes, and places acknowledges on the same cycles as new events.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int CODE_W = 4;
  localparam int IDX_W  = CODE_W - 1;
  localparam int MASK_N = 4;
  localparam int MASK_LO = 3;

  localparam logic [CODE_W-1:0] CODE_ILLEGAL = 4'd2;
  localparam logic [CODE_W-1:0] CODE_DIVZ    = 4'd4;
  localparam logic [CODE_W-1:0] CODE_ICVT    = 4'd6;
  localparam logic [CODE_W-1:0] CODE_OVF     = 4'd8;
  localparam logic [CODE_W-1:0] CODE_UNF     = 4'd10;
  localparam logic [CODE_W-1:0] CODE_UNDEF   = 4'd12;

  function automatic logic [IDX_W-1:0] fx_index(input logic [CODE_W-1:0] c);
    return c[CODE_W-1:1];
  endfunction

  function automatic logic fx_cancels(input logic [CODE_W-1:0] c, input logic masked);
    return (c == CODE_ILLEGAL) || (c == CODE_DIVZ) || ((c == CODE_UNDEF) && !masked);
  endfunction
endpackage

// File: rtl/fpx_undef_detect.sv
module fpx_undef_detect
  import fpx_pkg::*;
#(
  parameter int EXP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              opnd_valid,
  input  logic              opnd_sign,
  input  logic [EXP_W-1:0]  opnd_exp,
  output logic              ev_valid,
  output logic [CODE_W-1:0] ev_code
);
  logic undef_hit;

  assign undef_hit = opnd_valid && opnd_sign && (opnd_exp == '0);
  assign ev_valid  = exc_valid || undef_hit;
  assign ev_code   = exc_valid ? exc_code : CODE_UNDEF;

  assert_undef_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (opnd_valid && opnd_sign && (opnd_exp == '0)) |-> ev_valid);
endmodule

// File: rtl/fpx_mask_select.sv
module fpx_mask_select
  import fpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [CODE_W-1:0] ev_code,
  input  logic [MASK_N-1:0] en_mask,
  output logic              masked,
  output logic              fire,
  output logic              nop_insn
);
  logic [IDX_W-1:0]  idx;
  logic [MASK_N-1:0] sel;

  assign idx = fx_index(ev_code);

  for (genvar i = 0; i < MASK_N; i++) begin : g_sel
    assign sel[i] = (idx == IDX_W'(MASK_LO + i));
  end

  assign masked   = ev_valid && |(sel & ~en_mask);
  assign fire     = ev_valid && !masked;
  assign nop_insn = ev_valid && fx_cancels(ev_code, masked);

  assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
  assert_nop_needs_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nop_insn |-> ev_valid);
endmodule

// File: rtl/fpx_trap_hold.sv
module fpx_trap_hold #(
  parameter int VEC_W = 9,
  parameter int unsigned TRAP_VECTOR = 'o244
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_req,
  input  logic             trap_ack,
  output logic             trap_req,
  output logic [VEC_W-1:0] trap_vec
);
  always_ff @(posedge clk) begin
    if (!rst_n)        trap_req <= 1'b0;
    else if (set_req)  trap_req <= 1'b1;
    else if (trap_ack) trap_req <= 1'b0;
  end

  assign trap_vec = trap_req ? VEC_W'(TRAP_VECTOR) : '0;

  assert_trap_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> trap_req);
  assert_trap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !trap_ack) |=> trap_req);
endmodule

// File: rtl/fpx_trap_gate.sv
module fpx_trap_gate
  import fpx_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int EXP_W  = 8,
  parameter int VEC_W  = 9,
  parameter int unsigned TRAP_VECTOR = 'o244
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [ADDR_W-1:0] insn_addr,
  input  logic              opnd_valid,
  input  logic              opnd_sign,
  input  logic [EXP_W-1:0]  opnd_exp,
  input  logic [MASK_N-1:0] en_mask,
  input  logic              int_dis,
  input  logic              stat_wr,
  input  logic              stat_err_in,
  input  logic              trap_ack,
  output logic              trap_req,
  output logic [VEC_W-1:0]  trap_vec,
  output logic              nop_insn,
  output logic              err_flag,
  output logic [CODE_W-1:0] code_reg,
  output logic [ADDR_W-1:0] addr_reg
);
  logic              ev_valid;
  logic [CODE_W-1:0] ev_code;
  logic              masked;
  logic              fire;
  logic              set_trap;

  fpx_undef_detect #(.EXP_W(EXP_W)) u_detect (
    .clk(clk), .rst_n(rst_n),
    .exc_valid(exc_valid), .exc_code(exc_code),
    .opnd_valid(opnd_valid), .opnd_sign(opnd_sign), .opnd_exp(opnd_exp),
    .ev_valid(ev_valid), .ev_code(ev_code)
  );

  fpx_mask_select u_mask (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_code(ev_code), .en_mask(en_mask),
    .masked(masked), .fire(fire), .nop_insn(nop_insn)
  );

  assign set_trap = fire && !int_dis;

  fpx_trap_hold #(.VEC_W(VEC_W), .TRAP_VECTOR(TRAP_VECTOR)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .set_req(set_trap), .trap_ack(trap_ack),
    .trap_req(trap_req), .trap_vec(trap_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_flag <= 1'b0;
      code_reg <= '0;
      addr_reg <= '0;
    end else begin
      if (fire) begin
        err_flag <= 1'b1;
        code_reg <= ev_code;
        addr_reg <= insn_addr;
      end else if (stat_wr) begin
        err_flag <= stat_err_in;
      end
    end
  end

  assert_masked_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && masked && !stat_wr) |=> ($stable(err_flag) && $stable(code_reg)));
  assert_masked_no_trap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_req && ev_valid && masked) |=> !trap_req);
  assert_err_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> err_flag);
endmodule

// File: tb/fpx_trap_gate_test.sv
module fpx_trap_gate_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        exc_valid;
  logic [3:0]  exc_code;
  logic [15:0] insn_addr;
  logic        opnd_valid, opnd_sign;
  logic [7:0]  opnd_exp;
  logic [3:0]  en_mask;
  logic        int_dis, stat_wr, stat_err_in, trap_ack;
  logic        trap_req, nop_insn, err_flag;
  logic [8:0]  trap_vec;
  logic [3:0]  code_reg;
  logic [15:0] addr_reg;

  int total = 0;
  int bad = 0;

  logic        m_trap, m_err;
  logic [3:0]  m_code;
  logic [15:0] m_addr;

  always #5 clk = ~clk;

  fpx_trap_gate uut (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
    .insn_addr(insn_addr), .opnd_valid(opnd_valid), .opnd_sign(opnd_sign),
    .opnd_exp(opnd_exp), .en_mask(en_mask), .int_dis(int_dis), .stat_wr(stat_wr),
    .stat_err_in(stat_err_in), .trap_ack(trap_ack), .trap_req(trap_req),
    .trap_vec(trap_vec), .nop_insn(nop_insn), .err_flag(err_flag),
    .code_reg(code_reg), .addr_reg(addr_reg)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp_v);
    total++;
    if (act != exp_v) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp_v);
    end
  endtask

  // R1 masking rule restated as a table walk
  function automatic logic b_masked(input logic [3:0] c, input logic [3:0] en);
    case (c)
      4'd6, 4'd7:   return !en[0];
      4'd8, 4'd9:   return !en[1];
      4'd10, 4'd11: return !en[2];
      4'd12, 4'd13: return !en[3];
      default:      return 1'b0;
    endcase
  endfunction

  function automatic logic b_nop(input logic [3:0] c, input logic m);
    if (c == 4'd2 || c == 4'd4) return 1'b1;
    if (c == 4'd12) return !m;
    return 1'b0;
  endfunction

  task automatic check_regs(input string tag);
    chk(tag, "trap_req", int'(trap_req), int'(m_trap));
    chk(tag, "trap_vec", int'(trap_vec), m_trap ? 164 : 0);
    chk(tag, "err_flag", int'(err_flag), int'(m_err));
    chk(tag, "code_reg", int'(code_reg), int'(m_code));
    chk(tag, "addr_reg", int'(addr_reg), int'(m_addr));
  endtask

  task automatic step(input logic ev, input logic [3:0] c, input logic [15:0] a,
                      input logic ov, input logic os, input logic [7:0] oe,
                      input logic [3:0] en, input logic dis, input logic sw,
                      input logic si, input logic ack, input string tag);
    logic e_v, e_m, e_f;
    logic [3:0] e_c;
    @(negedge clk);
    exc_valid = ev; exc_code = c; insn_addr = a; opnd_valid = ov; opnd_sign = os;
    opnd_exp = oe; en_mask = en; int_dis = dis; stat_wr = sw; stat_err_in = si;
    trap_ack = ack;
    e_v = ev || (ov && os && oe == 8'd0);
    e_c = ev ? c : 4'd12;
    e_m = e_v && b_masked(e_c, en);
    e_f = e_v && !e_m;
    #2;
    chk(tag, "nop_insn", int'(nop_insn), int'(e_v && b_nop(e_c, e_m)));
    @(posedge clk);
    if (e_f) begin
      m_err = 1'b1; m_code = e_c; m_addr = a;
    end else if (sw) m_err = si;
    if (e_f && !dis) m_trap = 1'b1;
    else if (ack) m_trap = 1'b0;
    #1;
    check_regs(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 4'd0, 16'h0, 0, 0, 8'h1, 4'hF, 0, 0, 0, 0, tag);
  endtask

  task automatic ack_it(input string tag);
    step(0, 4'd0, 16'h0, 0, 0, 8'h1, 4'hF, 0, 0, 0, 1, tag);
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; exc_valid = 0; exc_code = 0; insn_addr = 0; opnd_valid = 0;
    opnd_sign = 0; opnd_exp = 0; en_mask = 0; int_dis = 0; stat_wr = 0;
    stat_err_in = 0; trap_ack = 0;
    m_trap = 0; m_err = 0; m_code = 0; m_addr = 0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    check_regs("R9");

    // R2: overflow masked by en_mask[1]
    step(1, 4'd8, 16'h1111, 0, 0, 8'h5, 4'b1101, 0, 0, 0, 0, "R2");
    // R1: integer conversion enabled via en_mask[0] fires
    step(1, 4'd6, 16'h2222, 0, 0, 8'h5, 4'b0001, 0, 0, 0, 0, "R1");
    // R5: hold without ack
    idle("R5"); idle("R5");
    ack_it("R5");
    // R6: divide by zero cancels even with all enables clear
    step(1, 4'd4, 16'h3333, 0, 0, 8'h5, 4'b0000, 0, 0, 0, 0, "R6");
    ack_it("R5");
    // R6: masked undefined variable from detector completes (no nop), R2 quiet
    step(0, 4'd0, 16'h4444, 1, 1, 8'h0, 4'b0111, 0, 0, 0, 0, "R6");
    // R7: detector event unmasked
    step(0, 4'd0, 16'h5555, 1, 1, 8'h0, 4'b1000, 0, 0, 0, 0, "R7");
    ack_it("R5");
    // R7: explicit code wins over detector
    step(1, 4'd10, 16'h6666, 1, 1, 8'h0, 4'b0100, 0, 0, 0, 0, "R7");
    // R4: int_dis blocks trap but sets flag; R8 stat write then clears err
    step(0, 4'd0, 16'h0, 0, 0, 8'h1, 4'hF, 0, 1, 0, 1, "R8");
    step(1, 4'd2, 16'h7777, 0, 0, 8'h1, 4'b0000, 1, 0, 0, 0, "R4");
    step(0, 4'd0, 16'h0, 0, 0, 8'h1, 4'hF, 0, 1, 0, 0, "R8");
    // R8: firing event overrides status write of 0
    step(1, 4'd14, 16'h8888, 0, 0, 8'h1, 4'b0000, 0, 1, 0, 0, "R8");
    // R5: new event in ack cycle keeps request
    step(1, 4'd0, 16'h9999, 0, 0, 8'h1, 4'b0000, 0, 0, 0, 1, "R5");
    ack_it("R5");
    // R1: code 12 masked by en_mask[3] only
    step(1, 4'd12, 16'hAAAA, 0, 0, 8'h1, 4'b0111, 0, 0, 0, 0, "R1");
    // R3: underflow enabled captures code and address
    step(1, 4'd10, 16'hBBBB, 0, 0, 8'h1, 4'b0100, 0, 0, 0, 0, "R3");

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] c;
      logic [7:0] oe;
      c  = 4'(2 * ($urandom % 8));
      oe = ($urandom % 3 == 0) ? 8'd0 : 8'($urandom);
      step(($urandom % 3) == 0, c, 16'($urandom), ($urandom % 4) == 0, 1'($urandom),
           oe, 4'($urandom), ($urandom % 4) == 0, ($urandom % 6) == 0, 1'($urandom),
           ($urandom % 3) == 0, "R1");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule